// File: doc/BRIEF.md
# Status and LED Output Pin Generator

This block computes the level of one general-purpose output pin for a sound-playback controller. Two configuration inputs set what the pin does. A function select chooses between status behaviour and LED behaviour, and a 2-bit code chooses the variant inside that function. Status variants follow the playback busy flag and the end-of-playback stop event. LED variants blink at one of two rates supplied as tick enables, compare the current 8-bit decoded amplitude code with a fixed fraction of full scale, or hold a constant LED on or LED off level. A third configuration input sets the pin level while reset is asserted.

The same RTL serves three port flavours, chosen by a parameter. The flavours differ only in how the 2-bit code maps to a behaviour. The pin is registered, so it changes one clock after the inputs it depends on.

Top module: `status_led_port`

## Requirements
- R1: While `rst` is high, `pin_o` takes the value of `opt_init_high_i` at each clock edge.
- R2: With `opt_led_i`=0 (status function) and `opt_code_i`=2'b00, `pin_o` equals `busy_i` on every port flavour, one clock later.
- R3: With `opt_led_i`=0, code 2'b01 holds `pin_o` low and code 2'b11 holds it high on every flavour, regardless of `busy_i`.
- R4: On flavours A and B, status code 2'b10 produces a single pulse. A `stop_pulse_i` arms it. The next `slow_tick_i` drives the pin high, and the following `slow_tick_i` drives it low again, so the pulse is exactly one slow period long. Fast ticks do not affect it, and a stop event while armed or high is ignored.
- R5: On flavour C, status code 2'b10 drives `pin_o` to the inverse of `busy_i`.
- R6: With `opt_led_i`=1, "LED on" is a constant low level and "LED off" is a constant high level. Code 2'b11 is off on flavour A and on on flavour B. On flavour C, code 2'b10 is on and code 2'b11 is off.
- R7: With `opt_led_i`=1, code 2'b00 blinks at the fast rate and code 2'b01 at the slow rate. A phase bit for each rate toggles on its tick while busy and is cleared while not busy. The positive variants (flavours A and C) drive the inverted phase, and the negative variant (flavour B) drives the phase itself. While not busy, all blink variants drive high.
- R8: With `opt_led_i`=1 and code 2'b10, flavour A compares `amp_i` with 179 and flavour B compares it with 230. While busy, the pin is low when `amp_i` exceeds the threshold and high otherwise. While not busy, it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opt_led_i | input | 1 | 0 = status function, 1 = LED function |
| opt_code_i | input | 2 | Variant code within the chosen function |
| opt_init_high_i | input | 1 | Pin level applied during reset |
| busy_i | input | 1 | Playback in progress |
| stop_pulse_i | input | 1 | One-cycle end-of-playback event |
| amp_i | input | AMP_W | Current decoded amplitude code |
| fast_tick_i | input | 1 | One-cycle enable at the fast blink rate |
| slow_tick_i | input | 1 | One-cycle enable at the slow blink rate |
| pin_o | output | 1 | Output pin level |

## Verification
Each behaviour mapping is exercised on all three flavours side by side. A wrong code-to-behaviour decode shows at the pin within two clocks of an option change. A corrupted blink phase shows as flavours A and B failing to stay mutually inverted, or as the pin moving on the wrong tick, two clocks after that tick. A wrong single-pulse state appears as a pin that rises before the first slow tick, or that fails to fall on the second. The threshold boundary is probed exactly at the constant and one above it, so an off-by-one comparison shows immediately.

// File: rtl/opgen_pkg.sv
package opgen_pkg;

    typedef enum logic [1:0] {
        PORT_A = 2'd0,
        PORT_B = 2'd1,
        PORT_C = 2'd2
    } port_kind_e;

    typedef enum logic [2:0] {
        K_BUSY,
        K_CONST,
        K_PULSE,
        K_BLINK,
        K_THRESH
    } beh_kind_e;

    // inv: busy polarity / blink polarity; slow: blink rate; level: constant value
    typedef struct packed {
        beh_kind_e kind;
        logic      inv;
        logic      slow;
        logic      level;
    } beh_t;

    // Rounded fraction (num/10) of a full-scale code of the given width.
    function automatic int unsigned frac_of_full(int unsigned width, int unsigned num);
        int unsigned fs;
        fs = (1 << width) - 1;
        return (fs * num + 5) / 10;
    endfunction

    function automatic int unsigned thresh_for(port_kind_e k, int unsigned width);
        case (k)
            PORT_A:  return frac_of_full(width, 7);
            PORT_B:  return frac_of_full(width, 9);
            default: return (1 << width) - 1;
        endcase
    endfunction

    function automatic beh_t mk(beh_kind_e k, logic inv, logic slow, logic lvl);
        beh_t b;
        b.kind  = k;
        b.inv   = inv;
        b.slow  = slow;
        b.level = lvl;
        return b;
    endfunction

    function automatic beh_t pick_beh(port_kind_e k, logic led, logic [1:0] code);
        beh_t b;
        b = mk(K_CONST, 1'b0, 1'b0, 1'b1);
        if (!led) begin
            case (code)
                2'b00: b = mk(K_BUSY,  1'b0, 1'b0, 1'b0);
                2'b01: b = mk(K_CONST, 1'b0, 1'b0, 1'b0);
                2'b10: b = (k == PORT_C) ? mk(K_BUSY, 1'b1, 1'b0, 1'b0)
                                         : mk(K_PULSE, 1'b0, 1'b0, 1'b0);
                default: b = mk(K_CONST, 1'b0, 1'b0, 1'b1);
            endcase
        end else begin
            case (code)
                2'b00: b = mk(K_BLINK, (k == PORT_B), 1'b0, 1'b0);
                2'b01: b = mk(K_BLINK, (k == PORT_B), 1'b1, 1'b0);
                2'b10: b = (k == PORT_C) ? mk(K_CONST, 1'b0, 1'b0, 1'b0)
                                         : mk(K_THRESH, 1'b0, 1'b0, 1'b0);
                default: b = mk(K_CONST, 1'b0, 1'b0, (k != PORT_B));
            endcase
        end
        return b;
    endfunction

endpackage

// File: rtl/opgen_blinker.sv
module opgen_blinker (
    input  logic clk,
    input  logic rst,
    input  logic busy_i,
    input  logic tick_i,
    output logic phase_o
);
    always_ff @(posedge clk) begin
        if (rst || !busy_i) phase_o <= 1'b0;
        else if (tick_i)    phase_o <= ~phase_o;
    end

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy_i && !tick_i) |=> $stable(phase_o)); // R7
    AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (busy_i && tick_i) |=> (phase_o != $past(phase_o))); // R7
endmodule

// File: rtl/opgen_stop_pulse.sv
module opgen_stop_pulse (
    input  logic clk,
    input  logic rst,
    input  logic stop_i,
    input  logic slow_tick_i,
    output logic pulse_o
);
    typedef enum logic [1:0] {P_IDLE, P_ARMED, P_HIGH} pstate_e;
    pstate_e st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= P_IDLE;
        end else begin
            case (st_q)
                P_IDLE:  if (stop_i)      st_q <= P_ARMED;
                P_ARMED: if (slow_tick_i) st_q <= P_HIGH;
                P_HIGH:  if (slow_tick_i) st_q <= P_IDLE;
                default:                  st_q <= P_IDLE;
            endcase
        end
    end

    assign pulse_o = (st_q == P_HIGH);

    AST_PULSE_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_o) |-> $past(slow_tick_i)); // R4
    AST_PULSE_FALL_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (pulse_o && slow_tick_i) |=> !pulse_o); // R4
endmodule

// File: rtl/opgen_amp_cmp.sv
module opgen_amp_cmp #(
    parameter int AMP_W  = 8,
    parameter int THRESH = 179
) (
    input  logic [AMP_W-1:0] amp_i,
    output logic             over_o
);
    localparam logic [AMP_W-1:0] THR_V = AMP_W'(THRESH);
    assign over_o = (amp_i > THR_V);
endmodule

// File: rtl/status_led_port.sv
module status_led_port
    import opgen_pkg::*;
#(
    parameter port_kind_e PORT_KIND = PORT_A,
    parameter int         AMP_W     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             opt_led_i,
    input  logic [1:0]       opt_code_i,
    input  logic             opt_init_high_i,
    input  logic             busy_i,
    input  logic             stop_pulse_i,
    input  logic [AMP_W-1:0] amp_i,
    input  logic             fast_tick_i,
    input  logic             slow_tick_i,
    output logic             pin_o
);
    localparam int THR   = int'(thresh_for(PORT_KIND, AMP_W));
    localparam int RATES = 2;

    beh_t             beh;
    logic [RATES-1:0] ticks;
    logic [RATES-1:0] phase;
    logic             pulse;
    logic             over;
    logic             pin_d;

    assign beh   = pick_beh(PORT_KIND, opt_led_i, opt_code_i);
    assign ticks = {slow_tick_i, fast_tick_i};

    for (genvar g = 0; g < RATES; g++) begin : g_rate
        opgen_blinker u_blk (
            .clk     (clk),
            .rst     (rst),
            .busy_i  (busy_i),
            .tick_i  (ticks[g]),
            .phase_o (phase[g])
        );
    end

    opgen_stop_pulse u_pulse (
        .clk         (clk),
        .rst         (rst),
        .stop_i      (stop_pulse_i),
        .slow_tick_i (slow_tick_i),
        .pulse_o     (pulse)
    );

    opgen_amp_cmp #(.AMP_W(AMP_W), .THRESH(THR)) u_cmp (
        .amp_i  (amp_i),
        .over_o (over)
    );

    always_comb begin
        case (beh.kind)
            K_BUSY:   pin_d = busy_i ^ beh.inv;
            K_CONST:  pin_d = beh.level;
            K_PULSE:  pin_d = pulse;
            K_BLINK:  pin_d = busy_i ? (phase[beh.slow] ^ ~beh.inv) : 1'b1;
            K_THRESH: pin_d = busy_i ? ~over : 1'b1;
            default:  pin_d = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pin_o <= opt_init_high_i;
        else     pin_o <= pin_d;
    end

    AST_INIT_LEVEL: assert property (@(posedge clk)
        rst |=> (pin_o == $past(opt_init_high_i))); // R1
    AST_BUSY_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (!opt_led_i && opt_code_i == 2'b00) |=> (pin_o == $past(busy_i))); // R2
    AST_CONST_LOW: assert property (@(posedge clk) disable iff (rst)
        (!opt_led_i && opt_code_i == 2'b01) |=> !pin_o); // R3
    AST_CONST_HIGH: assert property (@(posedge clk) disable iff (rst)
        (!opt_led_i && opt_code_i == 2'b11) |=> pin_o); // R3
    AST_LED_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
        (opt_led_i && !opt_code_i[1] && !busy_i) |=> pin_o); // R7
    AST_THRESH_OVER_LOW: assert property (@(posedge clk) disable iff (rst)
        (PORT_KIND != PORT_C && opt_led_i && opt_code_i == 2'b10 && busy_i
         && int'(amp_i) > THR) |=> !pin_o); // R8
endmodule

// File: tb/status_led_port_tb.sv
module status_led_port_tb;
    import opgen_pkg::*;

    logic       clk = 1'b0;
    logic       rst;
    logic       opt_led;
    logic [1:0] opt_code;
    logic       opt_init;
    logic       busy;
    logic       stop_p;
    logic [7:0] amp;
    logic       ftick;
    logic       stick;
    logic       pin_a, pin_b, pin_c;
    int         n_chk  = 0;
    int         n_fail = 0;
    bit         done   = 1'b0;

    always #2.5 clk = ~clk;

    status_led_port #(.PORT_KIND(PORT_A)) u_dut (
        .clk(clk), .rst(rst), .opt_led_i(opt_led), .opt_code_i(opt_code),
        .opt_init_high_i(opt_init), .busy_i(busy), .stop_pulse_i(stop_p),
        .amp_i(amp), .fast_tick_i(ftick), .slow_tick_i(stick), .pin_o(pin_a));
    status_led_port #(.PORT_KIND(PORT_B)) u_dut_b (
        .clk(clk), .rst(rst), .opt_led_i(opt_led), .opt_code_i(opt_code),
        .opt_init_high_i(opt_init), .busy_i(busy), .stop_pulse_i(stop_p),
        .amp_i(amp), .fast_tick_i(ftick), .slow_tick_i(stick), .pin_o(pin_b));
    status_led_port #(.PORT_KIND(PORT_C)) u_dut_c (
        .clk(clk), .rst(rst), .opt_led_i(opt_led), .opt_code_i(opt_code),
        .opt_init_high_i(opt_init), .busy_i(busy), .stop_pulse_i(stop_p),
        .amp_i(amp), .fast_tick_i(ftick), .slow_tick_i(stick), .pin_o(pin_c));

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic fast_pulse();
        ftick = 1'b1; step(1); ftick = 1'b0; step(2);
    endtask

    task automatic slow_pulse();
        stick = 1'b1; step(1); stick = 1'b0; step(2);
    endtask

    task automatic set_mode(logic led, logic [1:0] code, logic b);
        opt_led = led; opt_code = code; busy = b; step(2);
    endtask

    task automatic t_reset();
        rst = 1'b1; opt_init = 1'b1; step(2);
        check("R1", "init high A", pin_a, 1'b1);
        check("R1", "init high C", pin_c, 1'b1);
        opt_init = 1'b0; step(2);
        check("R1", "init low A", pin_a, 1'b0);
        check("R1", "init low B", pin_b, 1'b0);
        rst = 1'b0; step(1);
    endtask

    task automatic t_busy_high();
        set_mode(1'b0, 2'b00, 1'b1);
        check("R2", "busy=1 A", pin_a, 1'b1);
        check("R2", "busy=1 C", pin_c, 1'b1);
        set_mode(1'b0, 2'b00, 1'b0);
        check("R2", "busy=0 B", pin_b, 1'b0);
        check("R2", "busy=0 C", pin_c, 1'b0);
    endtask

    task automatic t_constants();
        set_mode(1'b0, 2'b01, 1'b1);
        check("R3", "code01 A", pin_a, 1'b0);
        check("R3", "code01 C", pin_c, 1'b0);
        set_mode(1'b0, 2'b11, 1'b0);
        check("R3", "code11 B", pin_b, 1'b1);
        check("R3", "code11 C", pin_c, 1'b1);
    endtask

    task automatic t_single_pulse();
        set_mode(1'b0, 2'b10, 1'b0);
        check("R4", "idle A", pin_a, 1'b0);
        stop_p = 1'b1; step(1); stop_p = 1'b0; step(2);
        check("R4", "armed A before tick", pin_a, 1'b0);
        fast_pulse();
        check("R4", "fast tick no start B", pin_b, 1'b0);
        slow_pulse();
        check("R4", "high after 1st slow tick A", pin_a, 1'b1);
        check("R4", "high after 1st slow tick B", pin_b, 1'b1);
        stop_p = 1'b1; step(1); stop_p = 1'b0; step(1);
        fast_pulse();
        check("R4", "stop/fast ignored while high A", pin_a, 1'b1);
        slow_pulse();
        check("R4", "low after 2nd slow tick A", pin_a, 1'b0);
        slow_pulse();
        check("R4", "no retrigger from ignored stop A", pin_a, 1'b0);
    endtask

    task automatic t_busy_low_c();
        set_mode(1'b0, 2'b10, 1'b1);
        check("R5", "C busy=1", pin_c, 1'b0);
        set_mode(1'b0, 2'b10, 1'b0);
        check("R5", "C busy=0", pin_c, 1'b1);
    endtask

    task automatic t_led_on_off();
        set_mode(1'b1, 2'b11, 1'b1);
        check("R6", "A off", pin_a, 1'b1);
        check("R6", "B on", pin_b, 1'b0);
        check("R6", "C off", pin_c, 1'b1);
        set_mode(1'b1, 2'b10, 1'b1);
        check("R6", "C on", pin_c, 1'b0);
    endtask

    task automatic t_blink();
        set_mode(1'b1, 2'b00, 1'b0);
        check("R7", "idle fast A", pin_a, 1'b1);
        check("R7", "idle fast B", pin_b, 1'b1);
        set_mode(1'b1, 2'b00, 1'b1);
        check("R7", "fast ph0 A", pin_a, 1'b1);
        check("R7", "fast ph0 B", pin_b, 1'b0);
        fast_pulse();
        check("R7", "fast ph1 A", pin_a, 1'b0);
        check("R7", "fast ph1 B", pin_b, 1'b1);
        check("R7", "fast ph1 C", pin_c, 1'b0);
        fast_pulse();
        check("R7", "fast ph0 again A", pin_a, 1'b1);
        set_mode(1'b1, 2'b01, 1'b1);
        check("R7", "slow ph0 A", pin_a, 1'b1);
        fast_pulse();
        check("R7", "slow ignores fast A", pin_a, 1'b1);
        slow_pulse();
        check("R7", "slow ph1 A", pin_a, 1'b0);
        check("R7", "slow ph1 B", pin_b, 1'b1);
        set_mode(1'b1, 2'b01, 1'b0);
        check("R7", "idle slow B", pin_b, 1'b1);
    endtask

    task automatic t_threshold();
        amp = 8'd179; set_mode(1'b1, 2'b10, 1'b1);
        check("R8", "A amp=179", pin_a, 1'b1);
        amp = 8'd180; step(2);
        check("R8", "A amp=180", pin_a, 1'b0);
        check("R8", "B amp=180", pin_b, 1'b1);
        amp = 8'd230; step(2);
        check("R8", "B amp=230", pin_b, 1'b1);
        amp = 8'd231; step(2);
        check("R8", "B amp=231", pin_b, 1'b0);
        amp = 8'd255; set_mode(1'b1, 2'b10, 1'b0);
        check("R8", "A idle amp=255", pin_a, 1'b1);
        check("R8", "B idle amp=255", pin_b, 1'b1);
    endtask

    initial begin
        rst = 1'b1; opt_led = 1'b0; opt_code = 2'b00; opt_init = 1'b1;
        busy = 1'b0; stop_p = 1'b0; amp = 8'd0; ftick = 1'b0; stick = 1'b0;
        t_reset();
        t_busy_high();
        t_constants();
        t_single_pulse();
        t_busy_low_c();
        t_led_on_off();
        t_blink();
        t_threshold();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule